// File: doc/BRIEF.md
# Sequential Population Counter with Zero-Detect Exit

This block counts the set bits of a data word with one shift register and one small counter instead of an adder tree. A request on `start` while the block is idle captures the word. The block then examines the lowest bit, adds one to the tally when that bit is set, and moves the word one place toward the low end with a zero entering at the top. The loop ends as soon as every bit left in the register is clear. The run time therefore depends on the position of the highest set bit and not on the word width.

A small one-hot controller sequences the work. It has an idle state, an examine state that tests the low bit and the zero flag, a shift state, and an empty settle state. The settle state keeps the register contents that were just shifted away from the test that reads them. The word width is a parameter with a default of 16. The tally width follows from it as clog2(width+1), so a 32-bit build needs only a new parameter value.

Top module: `bitcount_seq`

## Requirements
- R1: When `ready` is high and `start` is sampled high at a rising edge, the word on `data` is captured. After that edge `ready` and `done` are low and `count` reads 0.
- R2: When a run ends, `count` equals the number of 1 bits in the captured word. `count` is clog2(WIDTH+1) bits wide and never exceeds WIDTH.
- R3: Let p be the index of the highest set bit of the captured word. `ready` returns high exactly 3*(p+1)+1 rising edges after the capturing edge. A word of all zeros takes exactly 1 edge.
- R4: While `ready` is low, `start` and `data` have no effect on the result, on the run time, or on the point where the next run begins.
- R5: `done` goes high together with `ready` at the end of a run. It only ever goes high while `ready` is high, and it stays high with `count` unchanged until the next accepted `start`.
- R6: `rst` is synchronous and active high, and it takes effect at any time, including mid-run. After the edge, `ready` is 1 and both `done` and `count` are 0.
- R7: During a run, `count` changes by 0 or +1 per clock. Two increments are never on consecutive clocks, because each examine is followed by a shift and a settle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, sampled only while idle |
| data | input | WIDTH | Word whose set bits are counted |
| count | output | clog2(WIDTH+1) | Tally, final when `ready` is high |
| ready | output | 1 | High while idle and able to accept `start` |
| done | output | 1 | High in idle after a completed run |

## Verification
Two functions can fall in the same cycle. One is the end of a run: the final examine, then the idle cycle that presents the result. The other is the acceptance of a new request. The bench holds `start` high across several runs in a row, so the single idle cycle must present `done` and the finished `count`, and at its closing edge capture the next word and clear the tally. A behavioural model, built from bit index and set-bit count, predicts `ready`, `done` and `count` for every clock. It also flags any loss of that one-cycle result window, a start taken one cycle early, or a start taken one cycle late.

// File: rtl/bc_pkg.sv
package bc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'b0001,
    ST_EXAM   = 4'b0010,
    ST_SHIFT  = 4'b0100,
    ST_SETTLE = 4'b1000
  } bc_state_e;

endpackage

// File: rtl/bc_shreg.sv
module bc_shreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             lsb_o,
  output logic             zero_o
);

  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= data_i;
    end else if (shift_i) begin
      word_q <= {1'b0, word_q[WIDTH-1:1]};
    end
  end

  assign lsb_o  = word_q[0];
  assign zero_o = ~|word_q;

endmodule

// File: rtl/bc_tally.sv
module bc_tally #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
  import bc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic zero_i,
  input  logic lsb_i,
  output logic load_o,
  output logic inc_o,
  output logic shift_o,
  output logic ready_o,
  output logic done_o
);

  bc_state_e state_q, state_d;
  logic      done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_EXAM;
      ST_EXAM:   state_d = zero_i ? ST_IDLE : ST_SHIFT;
      ST_SHIFT:  state_d = ST_SETTLE;
      ST_SETTLE: state_d = ST_EXAM;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        done_q <= 1'b0;
      end else if (state_q == ST_EXAM && zero_i) begin
        done_q <= 1'b1;
      end
    end
  end

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign inc_o   = (state_q == ST_EXAM) && lsb_i;
  assign shift_o = (state_q == ST_SHIFT);
  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;

endmodule

// File: rtl/bitcount_seq.sv
module bitcount_seq #(
  parameter  int WIDTH = 16,
  localparam int CW    = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] data,
  output logic [CW-1:0]    count,
  output logic             ready,
  output logic             done
);

  logic load, inc, shift, lsb, zero;

  bc_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .zero_i  (zero),
    .lsb_i   (lsb),
    .load_o  (load),
    .inc_o   (inc),
    .shift_o (shift),
    .ready_o (ready),
    .done_o  (done)
  );

  bc_shreg #(.WIDTH(WIDTH)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .shift_i (shift),
    .data_i  (data),
    .lsb_o   (lsb),
    .zero_o  (zero)
  );

  bc_tally #(.CW(CW)) u_tally (
    .clk     (clk),
    .rst     (rst),
    .clear_i (load),
    .inc_i   (inc),
    .count_o (count)
  );

endmodule

// File: rtl/bc_checker.sv
module bc_checker #(
  parameter  int WIDTH = 16,
  localparam int CW    = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] data,
  input logic [CW-1:0]    count,
  input logic             ready,
  input logic             done
);

  logic [WIDTH-1:0] data_seen;
  assign data_seen = data;

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (!ready && !done && count == '0)); // R1

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(count) <= WIDTH)); // R2

  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> ready); // R5

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> (ready && $stable(count) && $stable(done))); // R5

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ready && !done && count == '0)); // R6

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready)) |->
      (({1'b0, count} == {1'b0, $past(count)}) ||
       ({1'b0, count} == {1'b0, $past(count)} + 1'b1))); // R7

  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready) && count != $past(count)) |=> $stable(count)); // R7

endmodule

bind bitcount_seq bc_checker #(.WIDTH(WIDTH)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .data  (data),
  .count (count),
  .ready (ready),
  .done  (done)
);

// File: tb/bitcount_seq_tb_top.sv
module bitcount_seq_lane #(
  parameter int W = 16
) (
  input  logic clk,
  output logic finished,
  output int   n_chk,
  output int   n_fail
);

  localparam int CW = $clog2(W + 1);

  logic          rst;
  logic          start;
  logic [W-1:0]  data;
  logic [CW-1:0] count;
  logic          ready;
  logic          done;

  bitcount_seq #(.WIDTH(W)) dut_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .data  (data),
    .count (count),
    .ready (ready),
    .done  (done)
  );

  // behavioural model
  int    left;
  int    m_cnt;
  int    m_pend;
  bit    m_done;
  bit    m_just_loaded;
  string ctx;

  function automatic int hibit(logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) v[b] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  always @(posedge clk) begin
    m_just_loaded = 1'b0;
    if (rst) begin
      left = 0; m_cnt = 0; m_done = 1'b0;
    end else if (left == 0) begin
      if (start) begin
        left = 3 * (hibit(data) + 1) + 1;
        m_pend = $countones(data);
        m_cnt = 0; m_done = 1'b0; m_just_loaded = 1'b1;
      end
    end else begin
      left--;
      if (left == 0) begin
        m_done = 1'b1; m_cnt = m_pend;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  int  prev_cnt;
  bit  prev_busy;
  bit  prev_inc;

  initial begin
    n_chk = 0; n_fail = 0; prev_busy = 1'b0; prev_inc = 1'b0; prev_cnt = 0;
  end

  always @(negedge clk) begin
    n_chk++;
    if (ready !== (left == 0)) begin
      n_fail++;
      $display("FAIL %s W=%0d ready: actual %0b expected %0b",
               m_just_loaded ? "R1" : "R3", W, ready, left == 0);
    end
    n_chk++;
    if (done !== m_done) begin
      n_fail++;
      $display("FAIL R5 W=%0d done: actual %0b expected %0b", W, done, m_done);
    end
    if (left == 0 || m_just_loaded) begin
      n_chk++;
      if (int'(count) != m_cnt) begin
        n_fail++;
        $display("FAIL %s W=%0d count: actual %0d expected %0d",
                 m_just_loaded ? "R1" : ctx, W, count, m_cnt);
      end
    end
    if (left != 0 && prev_busy && !m_just_loaded) begin
      n_chk++;
      if (!((int'(count) == prev_cnt) || (int'(count) == prev_cnt + 1 && !prev_inc))) begin
        n_fail++;
        $display("FAIL R7 W=%0d step: actual %0d expected %0d or %0d",
                 W, count, prev_cnt, prev_cnt + 1);
      end
      prev_inc = (int'(count) != prev_cnt);
    end else begin
      prev_inc = 1'b0;
    end
    prev_busy = (left != 0);
    prev_cnt  = int'(count);
  end

  // stimulus
  task automatic run(input logic [W-1:0] w, input bit poke);
    while (!ready) @(negedge clk);
    data = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0; data = rnd_word();
    while (!ready) begin
      if (poke) begin
        start = 1'($urandom_range(0, 1));   // R4: must be ignored
        data  = rnd_word();
      end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    finished = 1'b0; rst = 1'b1; start = 1'b0; data = '0; ctx = "R6";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    ctx = "R2";
    run('0, 1'b0);
    run('1, 1'b0);
    for (int i = 0; i < W; i++) run(W'(1) << i, 1'b0);
    for (int i = 0; i < W; i++) run(~(W'(1) << i), 1'b0);
    begin
      logic [W-1:0] alt;
      for (int b = 0; b < W; b++) alt[b] = b[0];
      run(alt, 1'b0);
      run(~alt, 1'b0);
    end
    for (int k = 0; k < 20; k++) run(rnd_word(), 1'b0);
    ctx = "R4";
    for (int k = 0; k < 6; k++) run(rnd_word(), 1'b1);
    // back-to-back runs with start held high
    ctx = "R5";
    while (!ready) @(negedge clk);
    start = 1'b1; data = rnd_word();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      data = (k == 1) ? '0 : rnd_word();
      while (!ready) @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    // reset in the middle of a run
    ctx = "R6";
    data = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    ctx = "R2";
    run(rnd_word(), 1'b0);
    finished = 1'b1;
  end

endmodule

module bitcount_seq_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic fin16, fin32;
  int   c16, f16, c32, f32;

  bitcount_seq_lane #(.W(16)) lane16_i (.clk(clk), .finished(fin16), .n_chk(c16), .n_fail(f16));
  bitcount_seq_lane #(.W(32)) lane32_i (.clk(clk), .finished(fin32), .n_chk(c32), .n_fail(f32));

  initial begin
    int extra_chk;
    int extra_fail;
    extra_chk = 1; extra_fail = 0;
    fork
      wait (fin16 === 1'b1 && fin32 === 1'b1);
      repeat (150000) @(posedge clk);
    join_any
    disable fork;
    if (!(fin16 === 1'b1 && fin32 === 1'b1)) begin
      extra_fail = 1;
      $display("FAIL watchdog: actual unfinished expected finished");
    end
    @(negedge clk);
    $display("%0d/%0d checks passed",
             (c16 + c32 + extra_chk) - (f16 + f32 + extra_fail),
             c16 + c32 + extra_chk);
    $finish;
  end

endmodule